// File: doc/BRIEF.md
# Fence-Gated Round-Robin Request Scheduler

This block sits between a set of host work-request queues and a transaction builder. Each cycle it looks at the head request of every queue and grants one of them to a single valid/ready output. The choice is round-robin: the search starts at the queue after the one served last. Each request carries an opcode class, a fence flag and a payload tag. The output passes these on together with the number of the queue that won.

Every queue has its own counter of reads and atomics that it has issued but that have not yet completed. The counter goes up when a read or atomic request is accepted at the output. It goes down when a completion arrives for that queue with a read or atomic class. A fenced request waits until its own queue's counter is zero. While it waits, the arbiter passes over that queue, so the other queues keep flowing. Requests without a fence are never held back by outstanding operations.

Top module: `fence_rr_sched`

## Requirements
- R1: After reset every outstanding counter is zero and the round-robin search starts at queue 0. With no valid request, `out_valid` is low.
- R2: The search for a winner starts at the queue after the last granted one and wraps around. Under constant load, all queues receive grants that differ by at most one.
- R3: A request with the fence flag set is not granted while its own queue's outstanding count is non-zero. It is granted once the count returns to zero.
- R4: A request without the fence flag is granted regardless of its queue's outstanding count.
- R5: A queue that is not eligible is skipped. `out_valid` is high whenever any queue is eligible.
- R6: The opcode class is 2 bits: 0 = write/send, 1 = read, 2 = atomic, 3 = other. Only an accepted request of class 1 or 2 increments its queue's count.
- R7: A completion (`cmp_valid`) with class 1 or 2 decrements the count of queue `cmp_qid`. Completions of class 0 or 3 have no effect.
- R8: An accepted read/atomic and a read/atomic completion on the same queue in the same cycle leave that count unchanged.
- R9: The count saturates at 2^CNT_W-1. At that value the queue's read/atomic requests are not eligible. A completion that arrives when the count is zero is ignored.
- R10: The output fields are the winning queue's class, fence and tag, plus `out_qid`. `req_ready` is high only for the winner, and only while `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NQ | Per-queue request valid |
| req_ready | output | NQ | Per-queue request accepted |
| req_cls | input | 2*NQ | Per-queue opcode class, queue i at bits [2i+1:2i] |
| req_fence | input | NQ | Per-queue fence flag |
| req_tag | input | TAG_W*NQ | Per-queue payload tag, queue i at [TAG_W*i +: TAG_W] |
| out_valid | output | 1 | A granted request is presented |
| out_ready | input | 1 | Downstream accepts the request |
| out_qid | output | QID_W | Queue number of the granted request |
| out_cls | output | 2 | Class of the granted request |
| out_fence | output | 1 | Fence flag of the granted request |
| out_tag | output | TAG_W | Tag of the granted request |
| cmp_valid | input | 1 | Completion strobe |
| cmp_qid | input | QID_W | Queue the completion belongs to |
| cmp_cls | input | 2 | Class of the completed operation |

## Verification
The outstanding counters have no port of their own. A wrong count therefore shows up in how fenced requests are handled. A count that is too low lets a fenced request out while a read is still outstanding. A count that is too high, or one that wraps, holds a fenced request back after all its reads have drained. Either error appears on the first fenced request that reaches the head of the affected queue. A wrong round-robin pointer shows up at once, as a wrong `out_qid` on the very next grant while several queues are eligible.

// File: rtl/fence_sched_pkg.sv
package fence_sched_pkg;

    typedef enum logic [1:0] {
        OPC_WRSEND = 2'd0,
        OPC_READ   = 2'd1,
        OPC_ATOMIC = 2'd2,
        OPC_OTHER  = 2'd3
    } op_class_e;

    // True for classes whose completion must be awaited by a fence
    function automatic logic is_tracked(input logic [1:0] cls);
        return (cls == OPC_READ) || (cls == OPC_ATOMIC);
    endfunction

endpackage

// File: rtl/fs_pending_ctr.sv
module fs_pending_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             at_zero,
    output logic             at_max
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic do_inc, do_dec;

    assign at_zero = (cnt == '0);
    assign at_max  = (cnt == MAXV);
    assign do_inc  = inc && !at_max;
    assign do_dec  = dec && !at_zero;
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (do_inc && !do_dec)
            cnt <= cnt + 1'b1;
        else if (do_dec && !do_inc)
            cnt <= cnt - 1'b1;
    end

    // R8
    net_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && dec && cnt != '0 && cnt != MAXV) |=> cnt == $past(cnt));
    // R7
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
    // R6
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec && cnt != MAXV) |=> cnt == $past(cnt) + 1'b1);
    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == MAXV && !dec) |=> cnt == MAXV);
    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !inc) |=> cnt == '0);

endmodule

// File: rtl/fs_rr_arbiter.sv
module fs_rr_arbiter #(
    parameter int NQ    = 4,
    parameter int IDX_W = $clog2(NQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NQ-1:0]    elig,
    input  logic             advance,
    output logic [NQ-1:0]    grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             any
);
    logic [IDX_W-1:0] ptr;

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        for (int k = 0; k < NQ; k++) begin
            int j;
            j = (int'(ptr) + k) % NQ;
            if (!any && elig[j]) begin
                any       = 1'b1;
                grant[j]  = 1'b1;
                grant_idx = IDX_W'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (advance && any)
            ptr <= IDX_W'((int'(grant_idx) + 1) % NQ);
    end

    // R10
    onehot_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    // R5
    grant_elig_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> ((grant & elig) != '0));
    // R5
    work_conserve_chk: assert property (@(posedge clk) disable iff (rst)
        (elig != '0) |-> any);

endmodule

// File: rtl/fence_rr_sched.sv
module fence_rr_sched
    import fence_sched_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int TAG_W = 8,
    parameter int CNT_W = 4,
    parameter int QID_W = $clog2(NQ)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NQ-1:0]       req_valid,
    output logic [NQ-1:0]       req_ready,
    input  logic [2*NQ-1:0]     req_cls,
    input  logic [NQ-1:0]       req_fence,
    input  logic [TAG_W*NQ-1:0] req_tag,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [QID_W-1:0]    out_qid,
    output logic [1:0]          out_cls,
    output logic                out_fence,
    output logic [TAG_W-1:0]    out_tag,
    input  logic                cmp_valid,
    input  logic [QID_W-1:0]    cmp_qid,
    input  logic [1:0]          cmp_cls
);
    logic [NQ-1:0]    elig, grant, q_zero, q_full, q_inc, q_dec;
    logic [CNT_W-1:0] q_cnt [NQ];
    logic [QID_W-1:0] gidx;
    logic             any;

    for (genvar i = 0; i < NQ; i++) begin : g_queue
        logic [1:0] cls_i;
        assign cls_i   = req_cls[2*i +: 2];
        assign elig[i] = req_valid[i]
                       && !(req_fence[i] && !q_zero[i])
                       && !(is_tracked(cls_i) && q_full[i]);
        assign q_inc[i] = grant[i] && out_ready && is_tracked(cls_i);
        assign q_dec[i] = cmp_valid && (cmp_qid == QID_W'(i)) && is_tracked(cmp_cls);

        fs_pending_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk     (clk),
            .rst     (rst),
            .inc     (q_inc[i]),
            .dec     (q_dec[i]),
            .count   (q_cnt[i]),
            .at_zero (q_zero[i]),
            .at_max  (q_full[i])
        );
    end

    fs_rr_arbiter #(.NQ(NQ), .IDX_W(QID_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .elig      (elig),
        .advance   (out_ready),
        .grant     (grant),
        .grant_idx (gidx),
        .any       (any)
    );

    assign out_valid = any;
    assign out_qid   = gidx;
    assign out_cls   = req_cls[2*gidx +: 2];
    assign out_fence = req_fence[gidx];
    assign out_tag   = req_tag[TAG_W*gidx +: TAG_W];
    assign req_ready = grant & {NQ{out_ready}};

    // R3
    fence_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_fence) |-> (q_cnt[out_qid] == '0));
    // R4
    nofence_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid[0] && !req_fence[0] && !is_tracked(req_cls[1:0])) |-> out_valid);

endmodule

// File: tb/tb_fence_rr_sched.sv
`timescale 1ns/1ps
module tb_fence_rr_sched;
    localparam int NQ = 4, TAG_W = 8, CNT_W = 4, QID_W = 2;
    localparam int MAXC = (1 << CNT_W) - 1;

    logic clk = 0, rst = 1;
    logic [NQ-1:0] req_valid = '0, req_ready, req_fence = '0;
    logic [2*NQ-1:0] req_cls = '0;
    logic [TAG_W*NQ-1:0] req_tag = '0;
    logic out_valid, out_ready = 0, out_fence, cmp_valid = 0;
    logic [QID_W-1:0] out_qid, cmp_qid = '0;
    logic [1:0] out_cls, cmp_cls = '0;
    logic [TAG_W-1:0] out_tag;

    always #10 clk = ~clk;

    fence_rr_sched #(.NQ(NQ), .TAG_W(TAG_W), .CNT_W(CNT_W)) dut (.*);

    int n_chk = 0, n_fail = 0;
    logic sv [NQ]; logic sf [NQ]; logic [1:0] sc [NQ]; logic [7:0] st [NQ];
    logic rdy = 0, cv = 0; int cq = 0; logic [1:0] cc = 0;
    int mcnt [NQ]; int mptr = 0; int last_w = -1; int grants [NQ];

    function automatic logic trk(input logic [1:0] c);
        return c == 2'd1 || c == 2'd2;
    endfunction
    function automatic logic m_elig(input int j);
        return sv[j] && !(sf[j] && mcnt[j] != 0) && !(trk(sc[j]) && mcnt[j] == MAXC);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_req(input int q, input logic [1:0] c, input logic f, input logic [7:0] t);
        sv[q] = 1; sc[q] = c; sf[q] = f; st[q] = t;
    endtask

    task automatic step(input string tag);
        int w;
        logic [NQ-1:0] exp_rdy;
        logic inc_ok, dec_ok;
        @(negedge clk);
        for (int i = 0; i < NQ; i++) begin
            req_valid[i] = sv[i]; req_fence[i] = sf[i];
            req_cls[2*i +: 2] = sc[i]; req_tag[TAG_W*i +: TAG_W] = st[i];
        end
        out_ready = rdy; cmp_valid = cv; cmp_qid = QID_W'(cq); cmp_cls = cc;
        #5;
        w = -1;
        for (int k = 0; k < NQ; k++)
            if (w < 0 && m_elig((mptr + k) % NQ)) w = (mptr + k) % NQ;
        chk({tag, " valid"}, int'(out_valid), int'(w >= 0));
        exp_rdy = '0;
        if (w >= 0) begin
            chk({tag, " qid"}, int'(out_qid), w);
            chk({tag, " tag"}, int'(out_tag), int'(st[w]));
            chk({tag, " cls"}, int'(out_cls), int'(sc[w]));
            exp_rdy[w] = rdy;
        end
        chk({tag, " ready"}, int'(req_ready), int'(exp_rdy));
        if (out_valid && out_ready && out_fence) chk("R3 fence count", mcnt[out_qid], 0);
        @(posedge clk);
        inc_ok = (w >= 0) && rdy && trk(sc[w]);
        dec_ok = cv && trk(cc) && mcnt[cq] > 0;
        if (w >= 0 && rdy) begin
            grants[w]++; mptr = (w + 1) % NQ; sv[w] = 0; last_w = w;
            if (inc_ok) mcnt[w]++;
        end else last_w = -1;
        if (dec_ok) mcnt[cq]--;
        cv = 0;
    endtask

    task automatic complete(input int q, input logic [1:0] c, input string tag);
        cv = 1; cq = q; cc = c; step(tag);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int mn, mx;
        void'($urandom(32'd4242));
        for (int i = 0; i < NQ; i++) begin sv[i] = 0; sf[i] = 0; sc[i] = 0; st[i] = 0; mcnt[i] = 0; grants[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: idle after reset, then queue 0 served first
        rdy = 1;
        step("R1");
        for (int i = 0; i < NQ; i++) set_req(i, 2'd0, 0, 8'(8'h10 + i));
        step("R1"); chk("R1 first winner", last_w, 0);
        step("R2"); chk("R2 next winner", last_w, 1);
        step("R2"); step("R2");
        // R6/R3/R5/R7: read on q1, fenced write held, q2 flows
        set_req(1, 2'd1, 0, 8'hA1); step("R6");
        set_req(1, 2'd0, 1, 8'hA2); step("R3"); chk("R3 fenced held", last_w, -1);
        set_req(2, 2'd0, 0, 8'hB2); step("R5"); chk("R5 skip blocked", last_w, 2);
        complete(1, 2'd0, "R7"); step("R7"); chk("R7 write completion ignored", last_w, -1);
        complete(1, 2'd1, "R7"); step("R3"); chk("R3 fenced released", last_w, 1);
        // R4: unfenced passes with outstanding read
        set_req(1, 2'd2, 0, 8'hC1); step("R6");
        set_req(1, 2'd0, 0, 8'hC2); step("R4"); chk("R4 unfenced passes", last_w, 1);
        // R8: issue read with same-cycle completion -> count stays 1
        set_req(1, 2'd1, 0, 8'hD1); cv = 1; cq = 1; cc = 2'd2; step("R8");
        set_req(1, 2'd0, 1, 8'hD2); step("R8"); chk("R8 net zero keeps fence held", last_w, -1);
        complete(1, 2'd1, "R8"); step("R8"); chk("R8 released", last_w, 1);
        // R6: class other not tracked
        set_req(0, 2'd3, 0, 8'hE1); step("R6");
        set_req(0, 2'd0, 1, 8'hE2); step("R6"); chk("R6 other untracked", last_w, 0);
        // R9: saturation on q2
        for (int n = 0; n < MAXC; n++) begin set_req(2, 2'd1, 0, 8'(n)); step("R9"); end
        set_req(2, 2'd1, 0, 8'hF0); step("R9"); chk("R9 read blocked at max", last_w, -1);
        set_req(2, 2'd0, 0, 8'hF1); step("R9"); chk("R9 write passes at max", last_w, 2);
        for (int n = 0; n <= MAXC; n++) complete(2, 2'd1, "R9");
        set_req(2, 2'd1, 0, 8'hF2); step("R9");
        complete(2, 2'd1, "R9");
        set_req(2, 2'd0, 1, 8'hF3); step("R9"); chk("R9 no underflow", last_w, 2);
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < NQ; i++)
                if (!sv[i] && ($urandom % 2 == 0))
                    set_req(i, 2'($urandom), ($urandom % 4 == 0), 8'($urandom));
            rdy = ($urandom % 4 != 0);
            cq = $urandom % NQ;
            if (mcnt[cq] > 0 && ($urandom % 2 == 0)) begin cv = 1; cc = 2'd1 + 2'($urandom % 2); end
            else if ($urandom % 8 == 0) begin cv = 1; cc = 2'($urandom); end
            step("R5");
        end
        // Fairness under constant load
        for (int i = 0; i < NQ; i++) begin sv[i] = 0; grants[i] = 0; end
        rdy = 1;
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < NQ; i++) if (!sv[i]) set_req(i, 2'd0, 0, 8'(n));
            step("R2");
        end
        mn = grants[0]; mx = grants[0];
        for (int i = 1; i < NQ; i++) begin
            if (grants[i] < mn) mn = grants[i];
            if (grants[i] > mx) mx = grants[i];
        end
        chk("R2 fairness spread", int'(mx - mn <= 1), 1);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule